// File: doc/BRIEF.md
# Debug Module Hart Handshake Window

This block is a memory-mapped window that sits between halted processor harts and a debug module. Harts reach it through a plain 32-bit read/write bus. They write their ID to acknowledge locations to report that they have halted, that they have taken a command, that they are resuming, or that they took an exception. They read a per-hart flag byte to learn what to do next. They also read the jump word, the command snippet, the program buffer and the debug ROM image. Two data words are writable scratch space for passing arguments.

On the debugger side, one-cycle request pulses ask the selected hart to run a command or to resume. The block keeps a GO and a RESUME flag for each hart, a halted bitmap, and a small command state machine. It reports the bitmap, a busy indication that lasts from command acceptance until the completing halt report, and a sticky exception indication. The ROM contents come in as a parameter array, and the other read-only words come in as input vectors.

Top module: `dbg_hart_window`

## Requirements
- R1: After a synchronous active-low reset, all GO and RESUME flags, the halted bitmap, busy, the exception indication and both data words are zero.
- R2: A bus write to byte offset 0x100 with a hart ID below NUM_HARTS in the write data sets that hart's halted bit. An out-of-range ID changes nothing.
- R3: A command request sets GO (flag bit 0) for the selected hart and raises busy, but only if that hart is halted and no command is busy. Otherwise the request is ignored.
- R4: A write to offset 0x108, whatever its data, clears GO of the hart running the command. Busy stays high until the next valid write to 0x100, which ends the command.
- R5: A resume request sets RESUME (flag bit 1) for the selected hart only when that hart is halted and no command is busy. A write to 0x110 with a hart ID clears that hart's RESUME flag and its halted bit.
- R6: A write to 0x118 aborts any pending command: busy drops and all GO flags clear. The exception output is then set and stays set until the next command is accepted.
- R7: A word read at 0x400+4k returns the flag bytes of harts 4k..4k+3, with the lowest hart in bits 7:0. Each byte holds GO in bit 0 and RESUME in bit 1, and its upper six bits are zero. Bytes for harts at or above NUM_HARTS read zero.
- R8: Reads at 0x300 return the jump word. Reads at 0x338+4i (i<10) return snippet word i, reads at 0x360+4i (i<8) return program buffer word i, and reads at 0x800+4i (i<ROM_WORDS) return ROM image word i.
- R9: Words at 0x380 and 0x384 read back the last value written to them and are driven on data_o, with word 0 in bits 31:0.
- R10: Reads from unmapped offsets and from the four acknowledge offsets return zero. Writes to read-only windows have no effect.
- R11: Every read returns its data with bus_rvalid high in the cycle after the request. Writes never raise bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data (hart ID for acknowledge writes) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cmd_req | input | 1 | Request: selected hart runs a command |
| resume_req | input | 1 | Request: selected hart resumes |
| sel_hart | input | HART_W | Selected hart ID |
| jump_word | input | 32 | Jump instruction served at 0x300 |
| snip_words | input | SNIP_WORDS*32 | Command snippet words, word 0 in low bits |
| prog_words | input | PROG_WORDS*32 | Program buffer words, word 0 in low bits |
| halted_o | output | NUM_HARTS | Halted bitmap, bit n is hart n |
| busy_o | output | 1 | A command is in flight |
| exc_o | output | 1 | Exception reported in debug mode |
| data_o | output | DATA_WORDS*32 | Data words, word 0 in low bits |

## Verification
A flag, halted bit or command state that is wrong inside the block shows up at the ports within one or two cycles. halted_o and busy_o follow the register state directly. A misplaced GO or RESUME bit appears in the flag word on the next read, one cycle after it is requested. A command state stuck in the wrong phase shows up as busy failing to fall on the completing halt write, or as GO still set after the acknowledge. The bench therefore reads the flag words after every handshake step and samples busy, exc and halted after every write.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE      = 2'd0,
        CMD_WAIT_ACK  = 2'd1,
        CMD_WAIT_DONE = 2'd2
    } cmd_state_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ACK_HALT,
        RG_ACK_GO,
        RG_ACK_RESUME,
        RG_ACK_EXC,
        RG_JUMP,
        RG_SNIP,
        RG_PROG,
        RG_DATA,
        RG_FLAGS,
        RG_ROM
    } region_e;

    // word indices (byte offset / 4) of each location
    localparam int unsigned WIX_HALT   = 'h40;
    localparam int unsigned WIX_GO     = 'h42;
    localparam int unsigned WIX_RESUME = 'h44;
    localparam int unsigned WIX_EXC    = 'h46;
    localparam int unsigned WIX_JUMP   = 'hC0;
    localparam int unsigned WIX_SNIP   = 'hCE;
    localparam int unsigned WIX_PROG   = 'hD8;
    localparam int unsigned WIX_DATA   = 'hE0;
    localparam int unsigned WIX_FLAGS  = 'h100;
    localparam int unsigned FLAG_WORDS = 64;
    localparam int unsigned WIX_ROM    = 'h200;

    localparam int unsigned FLAG_GO_BIT  = 0;
    localparam int unsigned FLAG_RES_BIT = 1;

endpackage

// File: rtl/dbgw_decode.sv
module dbgw_decode
    import dbgw_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int SNIP_WORDS = 10,
    parameter int PROG_WORDS = 8,
    parameter int DATA_WORDS = 2,
    parameter int ROM_WORDS  = 512,
    localparam int WA_W      = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [WA_W-1:0]   idx
);
    localparam logic [WA_W-1:0] B_HALT   = WA_W'(WIX_HALT);
    localparam logic [WA_W-1:0] B_GO     = WA_W'(WIX_GO);
    localparam logic [WA_W-1:0] B_RESUME = WA_W'(WIX_RESUME);
    localparam logic [WA_W-1:0] B_EXC    = WA_W'(WIX_EXC);
    localparam logic [WA_W-1:0] B_JUMP   = WA_W'(WIX_JUMP);
    localparam logic [WA_W-1:0] B_SNIP   = WA_W'(WIX_SNIP);
    localparam logic [WA_W-1:0] E_SNIP   = WA_W'(WIX_SNIP + SNIP_WORDS);
    localparam logic [WA_W-1:0] B_PROG   = WA_W'(WIX_PROG);
    localparam logic [WA_W-1:0] E_PROG   = WA_W'(WIX_PROG + PROG_WORDS);
    localparam logic [WA_W-1:0] B_DATA   = WA_W'(WIX_DATA);
    localparam logic [WA_W-1:0] E_DATA   = WA_W'(WIX_DATA + DATA_WORDS);
    localparam logic [WA_W-1:0] B_FLAGS  = WA_W'(WIX_FLAGS);
    localparam logic [WA_W-1:0] E_FLAGS  = WA_W'(WIX_FLAGS + FLAG_WORDS);
    localparam logic [WA_W-1:0] B_ROM    = WA_W'(WIX_ROM);
    localparam logic [WA_W-1:0] E_ROM    = WA_W'(WIX_ROM + ROM_WORDS);

    logic [WA_W-1:0] wa;
    logic [1:0]      unused_lsb;
    assign wa         = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (wa == B_HALT) begin
            region = RG_ACK_HALT;
        end else if (wa == B_GO) begin
            region = RG_ACK_GO;
        end else if (wa == B_RESUME) begin
            region = RG_ACK_RESUME;
        end else if (wa == B_EXC) begin
            region = RG_ACK_EXC;
        end else if (wa == B_JUMP) begin
            region = RG_JUMP;
        end else if (wa >= B_SNIP && wa < E_SNIP) begin
            region = RG_SNIP;
            idx    = wa - B_SNIP;
        end else if (wa >= B_PROG && wa < E_PROG) begin
            region = RG_PROG;
            idx    = wa - B_PROG;
        end else if (wa >= B_DATA && wa < E_DATA) begin
            region = RG_DATA;
            idx    = wa - B_DATA;
        end else if (wa >= B_FLAGS && wa < E_FLAGS) begin
            region = RG_FLAGS;
            idx    = wa - B_FLAGS;
        end else if (wa >= B_ROM && wa < E_ROM) begin
            region = RG_ROM;
            idx    = wa - B_ROM;
        end
    end

endmodule

// File: rtl/dbgw_ctrl.sv
module dbgw_ctrl
    import dbgw_pkg::*;
#(
    parameter int NUM_HARTS  = 4,
    parameter int DATA_WORDS = 2,
    parameter int WA_W       = 11,
    localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
    localparam int DIDX_W    = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  region_e                      region,
    input  logic [WA_W-1:0]              idx,
    input  logic [31:0]                  wdata,
    input  logic                         cmd_req,
    input  logic                         resume_req,
    input  logic [HART_W-1:0]            sel_hart,
    output logic [NUM_HARTS-1:0]         go_o,
    output logic [NUM_HARTS-1:0]         resume_o,
    output logic [NUM_HARTS-1:0]         halted_o,
    output logic                         busy_o,
    output logic                         exc_o,
    output logic [DATA_WORDS-1:0][31:0]  data_o
);
    typedef struct packed {
        logic [NUM_HARTS-1:0]        go;
        logic [NUM_HARTS-1:0]        resume;
        logic [NUM_HARTS-1:0]        halted;
        cmd_state_e                  st;
        logic [HART_W-1:0]           cmd_hart;
        logic                        exc;
        logic [DATA_WORDS-1:0][31:0] data;
    } ctrl_t;

    ctrl_t q, d;
    logic  wid_ok, sel_ok;
    logic [HART_W-1:0] wid;
    logic [WA_W-1:0]   unused_idx;

    assign unused_idx = idx;
    assign wid    = wdata[HART_W-1:0];
    assign wid_ok = wdata < 32'(NUM_HARTS);
    assign sel_ok = 32'(sel_hart) < 32'(NUM_HARTS);

    always_comb begin
        d = q;
        // debugger-side requests, only while no command is in flight
        if (q.st == CMD_IDLE && sel_ok && q.halted[sel_hart]) begin
            if (cmd_req) begin
                d.go[sel_hart] = 1'b1;
                d.st           = CMD_WAIT_ACK;
                d.cmd_hart     = sel_hart;
                d.exc          = 1'b0;
            end
            if (resume_req) begin
                d.resume[sel_hart] = 1'b1;
            end
        end
        // hart-side writes
        if (wr_en) begin
            unique case (region)
                RG_ACK_HALT: begin
                    if (wid_ok) begin
                        d.halted[wid] = 1'b1;
                        if (q.st == CMD_WAIT_DONE) d.st = CMD_IDLE;
                    end
                end
                RG_ACK_GO: begin
                    if (q.st == CMD_WAIT_ACK) begin
                        d.go[q.cmd_hart] = 1'b0;
                        d.st             = CMD_WAIT_DONE;
                    end
                end
                RG_ACK_RESUME: begin
                    if (wid_ok) begin
                        d.resume[wid] = 1'b0;
                        d.halted[wid] = 1'b0;
                    end
                end
                RG_ACK_EXC: begin
                    d.exc = 1'b1;
                    d.go  = '0;
                    d.st  = CMD_IDLE;
                end
                RG_DATA: begin
                    d.data[idx[DIDX_W-1:0]] = wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign go_o     = q.go;
    assign resume_o = q.resume;
    assign halted_o = q.halted;
    assign busy_o   = (q.st != CMD_IDLE);
    assign exc_o    = q.exc;
    assign data_o   = q.data;

    // R3
    busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_req));
    // R3
    go_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.go != '0) |-> (busy_o && $onehot0(q.go)));
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CMD_WAIT_DONE && !(wr_en && (region == RG_ACK_HALT || region == RG_ACK_EXC)))
        |=> busy_o);
    // R5
    resume_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.resume & ~q.halted) == '0);
    // R6
    exc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_o) |-> (!busy_o && q.go == '0));

endmodule

// File: rtl/dbgw_rdmux.sv
module dbgw_rdmux
    import dbgw_pkg::*;
#(
    parameter int NUM_HARTS  = 4,
    parameter int WA_W       = 11,
    parameter int SNIP_WORDS = 10,
    parameter int PROG_WORDS = 8,
    parameter int DATA_WORDS = 2,
    parameter int ROM_WORDS  = 512,
    parameter logic [ROM_WORDS-1:0][31:0] ROM_IMAGE = '0,
    localparam int SI_W = (SNIP_WORDS > 1) ? $clog2(SNIP_WORDS) : 1,
    localparam int PI_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1,
    localparam int DI_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int RI_W = (ROM_WORDS  > 1) ? $clog2(ROM_WORDS)  : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  region_e                      region,
    input  logic [WA_W-1:0]              idx,
    input  logic [31:0]                  jump_word,
    input  logic [SNIP_WORDS-1:0][31:0]  snip_words,
    input  logic [PROG_WORDS-1:0][31:0]  prog_words,
    input  logic [DATA_WORDS-1:0][31:0]  data_words,
    input  logic [NUM_HARTS-1:0]         go,
    input  logic [NUM_HARTS-1:0]         resume,
    output logic [31:0]                  rdata,
    output logic                         rvalid
);
    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rd_t;

    rd_t q, d;
    logic [31:0] flag_word;

    always_comb begin
        flag_word = '0;
        for (int b = 0; b < 4; b++) begin
            int unsigned h;
            h = 32'(idx) * 4 + 32'(b);
            if (h < 32'(NUM_HARTS)) begin
                flag_word[b*8 + FLAG_GO_BIT]  = go[h];
                flag_word[b*8 + FLAG_RES_BIT] = resume[h];
            end
        end
    end

    always_comb begin
        d.valid = rd_en;
        d.data  = '0;
        if (rd_en) begin
            unique case (region)
                RG_JUMP:  d.data = jump_word;
                RG_SNIP:  d.data = snip_words[idx[SI_W-1:0]];
                RG_PROG:  d.data = prog_words[idx[PI_W-1:0]];
                RG_DATA:  d.data = data_words[idx[DI_W-1:0]];
                RG_FLAGS: d.data = flag_word;
                RG_ROM:   d.data = ROM_IMAGE[idx[RI_W-1:0]];
                default:  d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.data;
    assign rvalid = q.valid;

    // R11
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en));
    // R10
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

endmodule

// File: rtl/dbg_hart_window.sv
module dbg_hart_window
    import dbgw_pkg::*;
#(
    parameter int NUM_HARTS  = 4,
    parameter int ADDR_W     = 13,
    parameter int SNIP_WORDS = 10,
    parameter int PROG_WORDS = 8,
    parameter int DATA_WORDS = 2,
    parameter int ROM_WORDS  = 512,
    parameter logic [ROM_WORDS-1:0][31:0] ROM_IMAGE = '0,
    localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    input  logic                       cmd_req,
    input  logic                       resume_req,
    input  logic [HART_W-1:0]          sel_hart,
    input  logic [31:0]                jump_word,
    input  logic [SNIP_WORDS*32-1:0]   snip_words,
    input  logic [PROG_WORDS*32-1:0]   prog_words,
    output logic [NUM_HARTS-1:0]       halted_o,
    output logic                       busy_o,
    output logic                       exc_o,
    output logic [DATA_WORDS*32-1:0]   data_o
);
    localparam int WA_W = ADDR_W - 2;

    region_e                     region;
    logic [WA_W-1:0]             idx;
    logic [NUM_HARTS-1:0]        go, resume;
    logic [DATA_WORDS-1:0][31:0] data_w;
    logic [SNIP_WORDS-1:0][31:0] snip_a;
    logic [PROG_WORDS-1:0][31:0] prog_a;

    assign snip_a = snip_words;
    assign prog_a = prog_words;
    assign data_o = data_w;

    dbgw_decode #(
        .ADDR_W(ADDR_W), .SNIP_WORDS(SNIP_WORDS), .PROG_WORDS(PROG_WORDS),
        .DATA_WORDS(DATA_WORDS), .ROM_WORDS(ROM_WORDS)
    ) u_decode (
        .addr(bus_addr), .region(region), .idx(idx)
    );

    dbgw_ctrl #(
        .NUM_HARTS(NUM_HARTS), .DATA_WORDS(DATA_WORDS), .WA_W(WA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_req && bus_we), .region(region),
        .idx(idx), .wdata(bus_wdata), .cmd_req(cmd_req), .resume_req(resume_req),
        .sel_hart(sel_hart), .go_o(go), .resume_o(resume), .halted_o(halted_o),
        .busy_o(busy_o), .exc_o(exc_o), .data_o(data_w)
    );

    dbgw_rdmux #(
        .NUM_HARTS(NUM_HARTS), .WA_W(WA_W), .SNIP_WORDS(SNIP_WORDS),
        .PROG_WORDS(PROG_WORDS), .DATA_WORDS(DATA_WORDS), .ROM_WORDS(ROM_WORDS),
        .ROM_IMAGE(ROM_IMAGE)
    ) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_req && !bus_we), .region(region),
        .idx(idx), .jump_word(jump_word), .snip_words(snip_a), .prog_words(prog_a),
        .data_words(data_w), .go(go), .resume(resume),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

endmodule

// File: tb/sim_dbg_hart_window.sv
module sim_dbg_hart_window;
    localparam int NH    = 6;
    localparam int HW    = 3;
    localparam int ROM_N = 16;
    localparam int AW    = 13;

    function automatic logic [ROM_N-1:0][31:0] mk_rom();
        logic [ROM_N-1:0][31:0] r;
        for (int i = 0; i < ROM_N; i++) r[i] = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0103);
        return r;
    endfunction
    localparam logic [ROM_N-1:0][31:0] ROM_T = mk_rom();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_rvalid;
    logic cmd_req = 1'b0, resume_req = 1'b0;
    logic [HW-1:0] sel_hart = '0;
    logic [31:0] jump_word = 32'h1234_006F;
    logic [10*32-1:0] snip_words;
    logic [8*32-1:0]  prog_words;
    logic [NH-1:0] halted_o;
    logic busy_o, exc_o;
    logic [63:0] data_o;

    always #2.5 clk = ~clk;

    initial begin
        for (int i = 0; i < 10; i++) snip_words[i*32 +: 32] = 32'h5000_0000 + 32'(i);
        for (int i = 0; i < 8; i++)  prog_words[i*32 +: 32] = 32'h7000_0000 + 32'(i);
    end

    dbg_hart_window #(
        .NUM_HARTS(NH), .ADDR_W(AW), .ROM_WORDS(ROM_N), .ROM_IMAGE(ROM_T)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cmd_req(cmd_req), .resume_req(resume_req),
        .sel_hart(sel_hart), .jump_word(jump_word), .snip_words(snip_words),
        .prog_words(prog_words), .halted_o(halted_o), .busy_o(busy_o),
        .exc_o(exc_o), .data_o(data_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected rvalid act=1 exp=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        @(negedge clk);
        sbq.push_back(e);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pulse_cmd(input logic [HW-1:0] s);
        @(negedge clk);
        sel_hart = s; cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
    endtask

    task automatic pulse_res(input logic [HW-1:0] s);
        @(negedge clk);
        sel_hart = s; resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 halted", 32'(halted_o), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 exc", 32'(exc_o), 0);
        chk("R1 data", data_o[31:0] | data_o[63:32], 0);
        rd(13'h400, 0, "R1 flags0");

        // R3 request to a running hart ignored
        pulse_cmd(3'd2);
        chk("R3 not halted busy", 32'(busy_o), 0);

        // R2 halt reports
        wr(13'h100, 2);
        chk("R2 halted h2", 32'(halted_o), 32'h04);
        wr(13'h100, 7);
        chk("R2 bad id ignored", 32'(halted_o), 32'h04);
        wr(13'h100, 5);
        chk("R2 halted h5", 32'(halted_o), 32'h24);

        // R3 accepted command
        pulse_cmd(3'd2);
        chk("R3 busy", 32'(busy_o), 1);
        rd(13'h400, 32'h0001_0000, "R3 R7 go h2");
        // R3 / R5 requests while busy ignored
        pulse_cmd(3'd5);
        pulse_res(3'd5);
        rd(13'h404, 0, "R3 R5 busy ignore");

        // R4 acknowledge and completion
        wr(13'h108, 32'hDEAD_BEEF);
        rd(13'h400, 0, "R4 go cleared");
        chk("R4 busy held", 32'(busy_o), 1);
        wr(13'h100, 2);
        chk("R4 done", 32'(busy_o), 0);

        // R5 resume
        pulse_res(3'd5);
        rd(13'h404, 32'h0000_0200, "R5 R7 resume h5");
        pulse_res(3'd3);
        rd(13'h400, 0, "R5 not halted");
        wr(13'h110, 5);
        rd(13'h404, 0, "R5 resume cleared");
        chk("R5 running", 32'(halted_o), 32'h04);

        // R6 exception abort
        pulse_cmd(3'd2);
        wr(13'h118, 0);
        chk("R6 busy", 32'(busy_o), 0);
        chk("R6 exc", 32'(exc_o), 1);
        rd(13'h400, 0, "R6 go cleared");
        pulse_cmd(3'd2);
        chk("R6 exc clear", 32'(exc_o), 0);
        chk("R6 busy again", 32'(busy_o), 1);
        wr(13'h108, 0);
        wr(13'h100, 2);
        chk("R4 done again", 32'(busy_o), 0);

        // R8 read-only windows
        rd(13'h300, 32'h1234_006F, "R8 jump");
        rd(13'h338 + 13'(4*9), 32'h5000_0009, "R8 snip9");
        rd(13'h360 + 13'(4*7), 32'h7000_0007, "R8 prog7");
        rd(13'h800 + 13'(4*5), ROM_T[5], "R8 rom5");

        // R9 data words
        wr(13'h380, 32'hCAFE_0001);
        wr(13'h384, 32'hBEEF_0002);
        rd(13'h380, 32'hCAFE_0001, "R9 data0");
        rd(13'h384, 32'hBEEF_0002, "R9 data1");
        chk("R9 data_o", data_o[63:32], 32'hBEEF_0002);

        // R10 zero reads and ignored writes
        rd(13'h100, 0, "R10 wo halt");
        rd(13'h004, 0, "R10 unmapped");
        rd(13'h3F0, 0, "R10 gap");
        rd(13'h800 + 13'(4*ROM_N), 0, "R10 past rom");
        rd(13'h4FC, 0, "R7 high harts");
        wr(13'h300, 32'hFFFF_FFFF);
        rd(13'h300, 32'h1234_006F, "R10 jump write ignored");
        wr(13'h804, 32'h0);
        rd(13'h804, ROM_T[1], "R10 rom write ignored");

        // R11 writes give no rvalid, all reads answered
        wr(13'h388, 32'h1);
        chk("R11 no rvalid on write", 32'(bus_rvalid), 0);
        repeat (2) @(negedge clk);
        chk("R11 all reads answered", 32'(sbq.size()), 0);
        summary();
    end

endmodule